// File: doc/BRIEF.md
# Passive Serial Configuration Loader

This block programs an SRAM-based programmable logic device over its passive serial configuration interface, using a bitstream held in a byte-wide memory. A one-cycle start strobe captures a first address, an end address and a ready-timeout limit. The block then pulls the device's active-low configuration request line low for a fixed time and releases it. It waits a settling time, then waits for the device's open-drain status input to read high.

After that it fetches one byte at a time through a simple request/valid read port. Each byte goes out most significant bit first on one data line, and every bit gets one pulse of a generated serial clock. Streaming stops in one of two ways. If the device raises its done input, the block sends a fixed run of extra clock pulses so the device can finish initialising, then reports success. If the read address reaches the end address first, the block reports failure at once.

A host starts the block and watches `busy_o`. When busy drops, `ok_o` or `fail_o` holds the outcome until the next start.

Top module: `ps_cfg_loader`

## Requirements
- R1: During and after reset, `cfg_req_n_o` is high, `dclk_o`, `data0_o`, `mem_req_o`, `busy_o`, `ok_o` and `fail_o` are low.
- R2: A start strobe while idle drives `cfg_req_n_o` low for exactly REQ_LOW_CYC cycles, after which it returns high. A start strobe while busy has no effect on the addresses used.
- R3: After `cfg_req_n_o` returns high, no serial clock rising edge occurs for at least SETTLE_CYC cycles, and none occurs while `status_i` is low.
- R4: Each byte is sent most significant bit first. `data0_o` changes only while `dclk_o` is low, and each clock phase lasts PHASE_CYC cycles.
- R5: Bytes are read from consecutive addresses starting at the captured first address. Each read raises `mem_req_o` with `mem_addr_o`, both held until `mem_valid_i`, and `mem_data_i` is taken in the cycle `mem_valid_i` is high.
- R6: `done_i` is examined between bytes. A byte already started is always completed.
- R7: When `done_i` is seen high, exactly TRAIL_CLKS further rising edges of `dclk_o` occur with `data0_o` low, then `ok_o` goes high.
- R8: When the read address equals or exceeds the end address while `done_i` is low, `fail_o` goes high with no further clock pulses. An empty window (end equal to first) sends no bytes.
- R9: With a nonzero timeout limit L, a status input that stays low for L cycles of waiting gives `fail_o` with no clock pulses. A limit of 0 waits indefinitely.
- R10: `busy_o` is high from the cycle after an accepted start until the result is posted. `ok_o` and `fail_o` are never both high and hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle start strobe |
| first_addr_i | input | ADDR_W | Address of the first bitstream byte |
| end_addr_i | input | ADDR_W | Address one past the last byte allowed |
| tmo_lim_i | input | TMO_W | Ready-wait limit in cycles, 0 disables |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | ADDR_W | Read address |
| mem_valid_i | input | 1 | Read data valid |
| mem_data_i | input | 8 | Read data byte |
| cfg_req_n_o | output | 1 | Active-low configuration request to the device |
| status_i | input | 1 | Device ready status (open-drain, high = ready) |
| done_i | input | 1 | Device configuration complete |
| dclk_o | output | 1 | Serial configuration clock |
| data0_o | output | 1 | Serial configuration data |
| busy_o | output | 1 | Sequence in progress |
| ok_o | output | 1 | Sequence ended successfully |
| fail_o | output | 1 | Sequence ended in failure |

## Verification
The bench builds the block with a 12-bit address, PHASE_CYC=2, REQ_LOW_CYC=6 and SETTLE_CYC=5. With these values, whole runs that include the full 4000 trailing clocks fit many times into the cycle budget. It sweeps the number of bytes before done and the size of an exhausted window over small ranges, including an empty window and one at the top of the address space. It also covers a done input that is already high at start, a status that never rises under a timeout, and a start strobe injected mid-run. Every bit is rebuilt from the serial pins and compared with an arithmetic byte pattern of the address.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PULL,
        ST_SETTLE,
        ST_WAIT_RDY,
        ST_FETCH,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_TRAIL_LO,
        ST_TRAIL_HI
    } ld_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/ps_delay_cnt.sv
module ps_delay_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/ps_shift8.sv
module ps_shift8
    import ps_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] din,
    input  logic              shift,
    output logic              msb,
    output logic              last
);
    localparam int IDX_W = $clog2(BYTE_W);

    logic [BYTE_W-1:0] sr_q;
    logic [IDX_W-1:0]  idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q  <= '0;
            idx_q <= '0;
        end else if (load) begin
            sr_q  <= din;
            idx_q <= '0;
        end else if (shift) begin
            sr_q  <= {sr_q[BYTE_W-2:0], 1'b0};
            idx_q <= idx_q + 1'b1;
        end
    end

    assign msb  = sr_q[BYTE_W-1];
    assign last = (idx_q == IDX_W'(BYTE_W - 1));
endmodule

// File: rtl/ps_cfg_loader.sv
module ps_cfg_loader
    import ps_cfg_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int PHASE_CYC   = 4,
    parameter int REQ_LOW_CYC = 64,
    parameter int SETTLE_CYC  = 2000,
    parameter int TRAIL_CLKS  = 4000,
    parameter int TMO_W       = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] first_addr_i,
    input  logic [ADDR_W-1:0] end_addr_i,
    input  logic [TMO_W-1:0]  tmo_lim_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_valid_i,
    input  logic [7:0]        mem_data_i,
    output logic              cfg_req_n_o,
    input  logic              status_i,
    input  logic              done_i,
    output logic              dclk_o,
    output logic              data0_o,
    output logic              busy_o,
    output logic              ok_o,
    output logic              fail_o
);
    localparam int DLY_MAX = max3(PHASE_CYC, REQ_LOW_CYC, SETTLE_CYC);
    localparam int DLY_W   = $clog2(DLY_MAX + 1);
    localparam int TRL_W   = $clog2(TRAIL_CLKS + 1);
    localparam logic [DLY_W-1:0] PH_LD  = DLY_W'(PHASE_CYC - 1);
    localparam logic [DLY_W-1:0] LOW_LD = DLY_W'(REQ_LOW_CYC - 1);
    localparam logic [DLY_W-1:0] SET_LD = DLY_W'(SETTLE_CYC - 1);

    ld_state_e         st_q, st_d;
    logic [ADDR_W-1:0] addr_q, end_q;
    logic [TMO_W-1:0]  tmo_lim_q, tmo_cnt_q;
    logic [TRL_W-1:0]  trail_q;
    logic              ok_q, fail_q;

    logic              dly_load, dly_exp;
    logic [DLY_W-1:0]  dly_val;
    logic              sh_load, sh_shift, sh_msb, sh_last;
    logic              in_window, tmo_hit, trail_last;

    ps_delay_cnt #(.W(DLY_W)) i_dly (
        .clk(clk), .rst(rst), .load(dly_load), .val(dly_val), .expired(dly_exp)
    );

    ps_shift8 i_shift (
        .clk(clk), .rst(rst), .load(sh_load), .din(mem_data_i),
        .shift(sh_shift), .msb(sh_msb), .last(sh_last)
    );

    assign in_window  = addr_q < end_q;
    assign tmo_hit    = (tmo_lim_q != '0) && (tmo_cnt_q == tmo_lim_q - 1'b1);
    assign trail_last = (trail_q == TRL_W'(TRAIL_CLKS - 1));

    always_comb begin
        st_d     = st_q;
        dly_load = 1'b0;
        dly_val  = PH_LD;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        case (st_q)
            ST_IDLE: if (start_i) begin
                st_d = ST_PULL; dly_load = 1'b1; dly_val = LOW_LD;
            end
            ST_PULL: if (dly_exp) begin
                st_d = ST_SETTLE; dly_load = 1'b1; dly_val = SET_LD;
            end
            ST_SETTLE: if (dly_exp) st_d = ST_WAIT_RDY;
            ST_WAIT_RDY: begin
                if (status_i)     st_d = ST_FETCH;
                else if (tmo_hit) st_d = ST_IDLE;
            end
            ST_FETCH: begin
                if (done_i) begin
                    st_d = ST_TRAIL_LO; dly_load = 1'b1;
                end else if (!in_window) begin
                    st_d = ST_IDLE;
                end else if (mem_valid_i) begin
                    st_d = ST_BIT_LO; dly_load = 1'b1; sh_load = 1'b1;
                end
            end
            ST_BIT_LO: if (dly_exp) begin
                st_d = ST_BIT_HI; dly_load = 1'b1;
            end
            ST_BIT_HI: if (dly_exp) begin
                if (sh_last) st_d = ST_FETCH;
                else begin
                    st_d = ST_BIT_LO; dly_load = 1'b1; sh_shift = 1'b1;
                end
            end
            ST_TRAIL_LO: if (dly_exp) begin
                st_d = ST_TRAIL_HI; dly_load = 1'b1;
            end
            ST_TRAIL_HI: if (dly_exp) begin
                if (trail_last) st_d = ST_IDLE;
                else begin
                    st_d = ST_TRAIL_LO; dly_load = 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            addr_q    <= '0;
            end_q     <= '0;
            tmo_lim_q <= '0;
            tmo_cnt_q <= '0;
            trail_q   <= '0;
            ok_q      <= 1'b0;
            fail_q    <= 1'b0;
        end else begin
            st_q <= st_d;
            case (st_q)
                ST_IDLE: if (start_i) begin
                    addr_q    <= first_addr_i;
                    end_q     <= end_addr_i;
                    tmo_lim_q <= tmo_lim_i;
                    tmo_cnt_q <= '0;
                    ok_q      <= 1'b0;
                    fail_q    <= 1'b0;
                end
                ST_WAIT_RDY: begin
                    tmo_cnt_q <= tmo_cnt_q + 1'b1;
                    if (!status_i && tmo_hit) fail_q <= 1'b1;
                end
                ST_FETCH: begin
                    if (done_i)          trail_q <= '0;
                    else if (!in_window) fail_q  <= 1'b1;
                end
                ST_BIT_HI: if (dly_exp && sh_last) addr_q <= addr_q + 1'b1;
                ST_TRAIL_HI: if (dly_exp) begin
                    if (trail_last) ok_q <= 1'b1;
                    else            trail_q <= trail_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign cfg_req_n_o = (st_q != ST_PULL);
    assign dclk_o      = (st_q == ST_BIT_HI) || (st_q == ST_TRAIL_HI);
    assign data0_o     = ((st_q == ST_BIT_LO) || (st_q == ST_BIT_HI)) && sh_msb;
    assign mem_req_o   = (st_q == ST_FETCH) && !done_i && in_window;
    assign mem_addr_o  = addr_q;
    assign busy_o      = (st_q != ST_IDLE);
    assign ok_o        = ok_q;
    assign fail_o      = fail_q;

    // R2: the request line is only driven low inside a running sequence
    a_r2_req_low_busy: assert property (@(posedge clk) disable iff (rst)
        !cfg_req_n_o |-> busy_o);

    // R4: data held steady across a high clock phase
    a_r4_data_stable_hi: assert property (@(posedge clk) disable iff (rst)
        (dclk_o && $past(dclk_o)) |-> $stable(data0_o));

    // R5: a pending read keeps its address
    a_r5_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_valid_i) |=> $stable(mem_addr_o));

    // R10: results exclusive, and busy only ends with a posted result
    a_r10_result_excl: assert property (@(posedge clk) disable iff (rst)
        !(ok_o && fail_o));

    a_r10_end_result: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (ok_o || fail_o));
endmodule

// File: tb/test_ps_cfg_loader.sv
module test_ps_cfg_loader;
    localparam int AW   = 12;
    localparam int PH   = 2;
    localparam int LOW  = 6;
    localparam int SET  = 5;
    localparam int TRL  = 4000;
    localparam int TW   = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [AW-1:0] sa = '0, ea = '0;
    logic [TW-1:0] tmo = '0;
    logic          mem_req_o, mem_valid_i = 1'b0;
    logic [AW-1:0] mem_addr_o;
    logic [7:0]    mem_data_i = '0;
    logic          cfg_req_n_o, status_i = 1'b0, done_i = 1'b0;
    logic          dclk_o, data0_o, busy_o, ok_o, fail_o;

    int checks = 0, errors = 0, cyc = 0;

    ps_cfg_loader #(.ADDR_W(AW), .PHASE_CYC(PH), .REQ_LOW_CYC(LOW),
                    .SETTLE_CYC(SET), .TRAIL_CLKS(TRL), .TMO_W(TW)) i_ps_cfg_loader (
        .clk(clk), .rst(rst), .start_i(start_i), .first_addr_i(sa), .end_addr_i(ea),
        .tmo_lim_i(tmo), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_valid_i(mem_valid_i), .mem_data_i(mem_data_i), .cfg_req_n_o(cfg_req_n_o),
        .status_i(status_i), .done_i(done_i), .dclk_o(dclk_o), .data0_o(data0_o),
        .busy_o(busy_o), .ok_o(ok_o), .fail_o(fail_o));

    always #2.5 clk = ~clk;

    function automatic logic [7:0] pat(input logic [AW-1:0] a);
        return 8'(int'(a) * 29 + 7);
    endfunction

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor state
    int rises = 0, bytes = 0, trail = 0, done_after = -1, st_delay = -1;
    int st_cnt = 0, low_cnt = 0, rel_cnt = 0;
    bit first_seen = 1'b0;
    logic [7:0]    sh = '0;
    logic [AW-1:0] base = '0;
    logic prev_dclk = 1'b0, prev_rn = 1'b1, prev_data = 1'b0, prev_req = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
        if (!rst) begin
            // device status model
            if (!cfg_req_n_o) begin
                st_cnt = 0; status_i = 1'b0;
            end else if (st_delay >= 0 && st_cnt >= st_delay) status_i = 1'b1;
            else st_cnt++;
            // R2 low time, R3 settle measurement
            if (!cfg_req_n_o) low_cnt++;
            if (cfg_req_n_o && !prev_rn) begin
                chk(low_cnt == LOW, "R2 request low time", low_cnt, LOW);
                rel_cnt = 0;
            end else if (cfg_req_n_o) rel_cnt++;
            // memory model, R5 address order
            if (mem_req_o && !prev_req)
                chk(mem_addr_o == base + AW'(bytes), "R5 read address",
                    int'(mem_addr_o), int'(base) + bytes);
            mem_data_i  = pat(mem_addr_o);
            mem_valid_i = mem_req_o && !mem_valid_i;
            // serial clock edges
            if (dclk_o && !prev_dclk) begin
                if (!status_i) chk(1'b0, "R3 clock before ready", 1, 0);
                if (!first_seen) begin
                    chk(rel_cnt >= SET, "R3 settle time", rel_cnt, SET);
                    first_seen = 1'b1;
                end
                if (done_i) begin
                    trail++;
                    if (data0_o) chk(1'b0, "R7 trailing data low", 1, 0);
                end else begin
                    sh = {sh[6:0], data0_o};
                    rises++;
                    if (rises % 8 == 0) begin
                        chk(sh == pat(base + AW'(bytes)), "R4 byte msb first",
                            int'(sh), int'(pat(base + AW'(bytes))));
                        bytes++;
                        if (done_after > 0 && bytes == done_after) done_i = 1'b1;
                    end
                end
            end
            if (dclk_o && prev_dclk && data0_o != prev_data)
                chk(1'b0, "R4 data changed while clock high", 1, 0);
        end
        prev_dclk = dclk_o; prev_rn = cfg_req_n_o; prev_data = data0_o; prev_req = mem_req_o;
    end

    task automatic run(input logic [AW-1:0] s, input logic [AW-1:0] e, input int dafter,
                       input int sdelay, input int tlim, input bit exp_ok,
                       input int exp_bytes, input int exp_trail, input bit poke,
                       input string req);
        int n;
        @(negedge clk);
        base = s; bytes = 0; rises = 0; trail = 0; low_cnt = 0; first_seen = 1'b0;
        done_after = dafter; st_delay = sdelay; done_i = (dafter == 0);
        sa = s; ea = e; tmo = TW'(tlim); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R10 busy after start", int'(busy_o), 1);
        n = 0;
        while (busy_o && n < 60000) begin
            @(negedge clk);
            n++;
            if (poke && n == 30) begin start_i = 1'b1; sa = s + 12'd100; end
            else start_i = 1'b0;
        end
        start_i = 1'b0;
        chk(ok_o == exp_ok, {req, " ok flag"}, int'(ok_o), int'(exp_ok));
        chk(fail_o == !exp_ok, {req, " fail flag"}, int'(fail_o), int'(!exp_ok));
        chk(bytes == exp_bytes, {req, " byte count"}, bytes, exp_bytes);
        chk(rises == exp_bytes * 8, {req, " data clocks"}, rises, exp_bytes * 8);
        chk(trail == exp_trail, "R7 trailing clocks", trail, exp_trail);
        repeat (3) @(negedge clk);
        chk(ok_o == exp_ok && fail_o == !exp_ok, "R10 result held",
            int'(ok_o), int'(exp_ok));
        chk(!busy_o && !dclk_o, "R8 quiet after end", int'(dclk_o), 0);
        done_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cfg_req_n_o == 1'b1, "R1 request idle high", int'(cfg_req_n_o), 1);
        chk(!dclk_o && !data0_o && !mem_req_o, "R1 serial idle low", int'(dclk_o), 0);
        chk(!busy_o && !ok_o && !fail_o, "R1 flags low", int'(busy_o), 0);
        rst = 1'b0;
        @(negedge clk);
        // R6 R7 R9: done after three bytes, timeout disabled, slow status
        run(12'h010, 12'h100, 3, 7, 0, 1'b1, 3, TRL, 1'b0, "R7");
        // sweep of bytes before done; second run injects a start while busy (R2)
        for (int k = 1; k <= 2; k++)
            run(12'h0F0 + AW'(k * 16), 12'h200, k, 0, 100, 1'b1, k, TRL, k == 2, "R6");
        // R8 window sweep including empty window
        for (int w = 0; w <= 4; w++)
            run(12'h300, 12'h300 + AW'(w), -1, 3, 0, 1'b0, w, 0, 1'b0, "R8");
        // R8 window at top of the address space
        run(12'hFFC, 12'hFFF, -1, 2, 0, 1'b0, 3, 0, 1'b0, "R8");
        // R6 done already high at start: no data, only trailing clocks
        run(12'h400, 12'h500, 0, 2, 0, 1'b1, 0, TRL, 1'b0, "R6");
        // R9 ready never arrives
        run(12'h020, 12'h030, -1, -1, 20, 1'b0, 0, 0, 1'b0, "R9");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule